// File: doc/BRIEF.md
# Option ROM Window with Shadow RAM Overlay

This block answers byte reads on a 16 KB option ROM window. The host gives it a wide memory address. The block keeps only the low 14 bits of that address, so every higher copy of the window aliases onto the same bytes. Behind the window sit two ROM banks, and a command picks which bank is visible. The ROM images are loaded through a separate load port, for example by boot logic or by a testbench, before the host reads them.

The top 128 bytes of the window can be covered by a small RAM, and two mode bits control the covering. One bit lets writes into that region land in the RAM. The other bit lets reads from that region return RAM bytes instead of ROM bytes. Firmware uses this to keep scratch data inside its own ROM address space. It can first run write-only so that the ROM stays visible, and then switch reads over. Writes anywhere else in the window are discarded.

Reads take one cycle: the byte appears on `bus_rdata` in the cycle after the read strobe and stays there until the next read. Commands arrive on a separate strobe with an opcode and an argument byte.

Top module: `rom_shadow_window`

## Requirements
- R1: Only the low 14 bits of `bus_addr` are decoded. Any two addresses that agree in those bits behave identically for reads and writes.
- R2: The overlay region covers masked addresses 0x3F80 to 0x3FFF. In that region the RAM byte used is the masked address modulo 128.
- R3: When mode bit 0 is set, a write into the overlay region stores `bus_wdata` in the shadow RAM. When mode bit 0 is clear, the write leaves the RAM unchanged.
- R4: When mode bit 1 is set, a read in the overlay region returns the shadow RAM byte. When mode bit 1 is clear, the read returns the ROM byte of the visible bank at that address.
- R5: A read below masked address 0x3F80 always returns the ROM byte of the visible bank, whatever the mode bits are.
- R6: Opcode 0x26 makes bank 0 visible and opcode 0x27 makes bank 1 visible. Any other opcode leaves the visible bank unchanged.
- R7: Opcode 0x24 loads the mode from `ctl_arg[1:0]`, where bit 0 is the write enable and bit 1 is the read enable. Bits 7:2 of the argument are ignored. No other opcode changes the mode.
- R8: While `rst_n` is low at a clock edge, the mode is cleared to 0 and bank 0 becomes visible.
- R9: A read strobed in cycle N shows its byte on `bus_rdata` in cycle N+1. That byte is held until the next read.
- R10: A write outside the overlay region changes no RAM byte, and a later read at the same address still returns the ROM byte.
- R11: A pulse on `rom_ld_en` writes `rom_ld_data` into bank `rom_ld_bank` at ROM index `rom_ld_addr`. ROM reads use the low 8 bits of the masked address as the index.
- R12: An access in the same cycle as a command uses the mode and bank held before that command. A read and a write to the same shadow byte in one cycle return the byte as it was before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 20 | Host byte address |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle after the read |
| ctl_valid | input | 1 | Command strobe |
| ctl_op | input | 8 | Command opcode (0x24 mode, 0x26 bank 0, 0x27 bank 1) |
| ctl_arg | input | 8 | Command argument; bits 1:0 are the mode |
| rom_ld_en | input | 1 | ROM image load strobe |
| rom_ld_bank | input | 1 | Bank being loaded |
| rom_ld_addr | input | 8 | ROM index being loaded |
| rom_ld_data | input | 8 | ROM byte being loaded |

## Verification
Two pairs of events can fall in the same cycle. A mode or bank command can arrive together with a bus read or write. A read and a write can also hit the same shadow byte together. The bench drives both pairs on purpose: it reads the overlay while switching read enable off, reads low ROM while switching bank, and strobes read and write together on one shadow byte. A behavioural model applies the pre-command state and read-before-write ordering, and on every clock it compares its expected byte with `bus_rdata`.

// File: rtl/rom_window_pkg.sv
// Package: shared opcodes and types for the option ROM window.
// Assumes two ROM banks and a two-bit shadow mode.
package rom_window_pkg;

    localparam logic [7:0] OP_SET_MODE = 8'h24;
    localparam logic [7:0] OP_BANK_LO  = 8'h26;
    localparam logic [7:0] OP_BANK_HI  = 8'h27;

    localparam int ROM_BANKS = 2;
    localparam int BANK_W    = $clog2(ROM_BANKS);

    // Bit 1 = read from shadow, bit 0 = write into shadow.
    typedef struct packed {
        logic rd_en;
        logic wr_en;
    } shadow_mode_t;

    typedef enum logic [BANK_W-1:0] {
        BANK_LO = 1'b0,
        BANK_HI = 1'b1
    } rom_bank_e;

endpackage

// File: rtl/rw_addr_decode.sv
// Address decode: masks the host address to the window and flags the
// shadow overlay at its top. Purely combinational.
// Assumes the overlay size is a power of two that is aligned to the window top.
module rw_addr_decode #(
    parameter int BUS_AW = 20,
    parameter int WIN_AW = 14,
    parameter int SH_AW  = 7
) (
    input  logic [BUS_AW-1:0] bus_addr,
    output logic [WIN_AW-1:0] win_addr,
    output logic              in_shadow,
    output logic [SH_AW-1:0]  sh_idx
);

    localparam int WIN_BYTES = 1 << WIN_AW;
    localparam int SH_BYTES  = 1 << SH_AW;
    localparam logic [WIN_AW-1:0] SH_BASE = WIN_AW'(WIN_BYTES - SH_BYTES);

    logic unused_hi;

    // Mask away everything above the window.
    assign win_addr  = bus_addr[WIN_AW-1:0];
    assign unused_hi = ^bus_addr[BUS_AW-1:WIN_AW];

    // Overlay compare and index inside the RAM.
    assign in_shadow = (win_addr >= SH_BASE);
    assign sh_idx    = win_addr[SH_AW-1:0];

endmodule

// File: rtl/rw_ctrl_regs.sv
// Control registers: the shadow mode and the visible ROM bank.
// They are updated by single-cycle commands. Unknown opcodes are ignored.
module rw_ctrl_regs
    import rom_window_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctl_valid,
    input  logic [7:0]   ctl_op,
    input  logic [7:0]   ctl_arg,
    output shadow_mode_t mode_q,
    output rom_bank_e    bank_q
);

    logic [5:0] unused_arg;
    assign unused_arg = ctl_arg[7:2];

    // Apply commands; reset clears the mode and shows the low bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            bank_q <= BANK_LO;
        end else if (ctl_valid) begin
            case (ctl_op)
                OP_SET_MODE: mode_q <= shadow_mode_t'(ctl_arg[1:0]);
                OP_BANK_LO:  bank_q <= BANK_LO;
                OP_BANK_HI:  bank_q <= BANK_HI;
                default:     ;
            endcase
        end
    end

    a_r8_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mode_q == '0 && bank_q == BANK_LO));

    a_r6_bank_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_op == 8'h26) |=> bank_q == BANK_LO);

    a_r6_bank_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_op == 8'h27) |=> bank_q == BANK_HI);

    a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_valid || ctl_op != 8'h24) |=> $stable(mode_q));

    a_r7_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_op == 8'h24) |=> mode_q == $past(ctl_arg[1:0]));

endmodule

// File: rtl/rw_rom_banks.sv
// ROM banks: one byte array per bank, filled through a load port.
// There is one registered read port for the visible bank. The read data is
// held between reads. Assumes loads and reads of the same byte do not collide.
module rw_rom_banks
    import rom_window_pkg::*;
#(
    parameter int ROM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [BANK_W-1:0] ld_bank,
    input  logic [ROM_AW-1:0] ld_idx,
    input  logic [7:0]        ld_data,
    input  logic              rd_en,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [ROM_AW-1:0] rd_idx,
    output logic [7:0]        rd_data
);

    localparam int ROM_DEPTH = 1 << ROM_AW;

    logic [7:0] bank_byte [ROM_BANKS];

    for (genvar b = 0; b < ROM_BANKS; b++) begin : g_bank
        logic [7:0] mem [ROM_DEPTH];

        // Accept image bytes for this bank.
        always_ff @(posedge clk) begin
            if (ld_en && ld_bank == BANK_W'(b)) begin
                mem[ld_idx] <= ld_data;
            end
        end

        assign bank_byte[b] = mem[rd_idx];
    end

    // Register the byte of the selected bank on a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= bank_byte[rd_bank];
        end
    end

    a_r9_rom_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/rw_shadow_ram.sv
// Shadow RAM: a small byte array with one write port and one registered
// read port. A read and a write to the same byte in one cycle return the old byte.
module rw_shadow_ram #(
    parameter int SH_AW = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SH_AW-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic             rd_en,
    input  logic [SH_AW-1:0] rd_idx,
    output logic [7:0]       rd_data
);

    localparam int SH_DEPTH = 1 << SH_AW;

    logic [7:0] mem [SH_DEPTH];

    // Store enabled writes.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Register the byte read, taken before any write in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= mem[rd_idx];
        end
    end

    a_r3_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem[$past(wr_idx)] == $past(wr_data));

    a_r9_ram_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/rom_shadow_window.sv
// Top: option ROM window with a shadow RAM overlay on its top bytes.
// It routes host reads to the ROM or the RAM, filters writes by the mode, and
// returns read data one cycle later. Assumes single-cycle strobes.
module rom_shadow_window
    import rom_window_pkg::*;
#(
    parameter int BUS_AW = 20,
    parameter int WIN_AW = 14,
    parameter int SH_AW  = 7,
    parameter int ROM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              ctl_valid,
    input  logic [7:0]        ctl_op,
    input  logic [7:0]        ctl_arg,
    input  logic              rom_ld_en,
    input  logic [BANK_W-1:0] rom_ld_bank,
    input  logic [ROM_AW-1:0] rom_ld_addr,
    input  logic [7:0]        rom_ld_data
);

    localparam logic [WIN_AW-1:0] SH_BASE =
        WIN_AW'((1 << WIN_AW) - (1 << SH_AW));

    logic [WIN_AW-1:0] win_addr;
    logic              in_shadow;
    logic [SH_AW-1:0]  sh_idx;
    shadow_mode_t      mode_q;
    rom_bank_e         bank_q;
    logic              ram_wr;
    logic              ram_rd;
    logic              rom_rd;
    logic              from_ram_q;
    logic [7:0]        ram_rdata;
    logic [7:0]        rom_rdata;

    rw_addr_decode #(
        .BUS_AW (BUS_AW),
        .WIN_AW (WIN_AW),
        .SH_AW  (SH_AW)
    ) u_dec (
        .bus_addr  (bus_addr),
        .win_addr  (win_addr),
        .in_shadow (in_shadow),
        .sh_idx    (sh_idx)
    );

    rw_ctrl_regs u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_valid (ctl_valid),
        .ctl_op    (ctl_op),
        .ctl_arg   (ctl_arg),
        .mode_q    (mode_q),
        .bank_q    (bank_q)
    );

    // Route strobes by the overlay compare and the mode bits.
    always_comb begin
        ram_wr = bus_wr && in_shadow && mode_q.wr_en;
        ram_rd = bus_rd && in_shadow && mode_q.rd_en;
        rom_rd = bus_rd && !ram_rd;
    end

    rw_shadow_ram #(
        .SH_AW (SH_AW)
    ) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ram_wr),
        .wr_idx  (sh_idx),
        .wr_data (bus_wdata),
        .rd_en   (ram_rd),
        .rd_idx  (sh_idx),
        .rd_data (ram_rdata)
    );

    rw_rom_banks #(
        .ROM_AW (ROM_AW)
    ) u_rom (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (rom_ld_en),
        .ld_bank (rom_ld_bank),
        .ld_idx  (rom_ld_addr),
        .ld_data (rom_ld_data),
        .rd_en   (rom_rd),
        .rd_bank (bank_q),
        .rd_idx  (win_addr[ROM_AW-1:0]),
        .rd_data (rom_rdata)
    );

    // Remember which store answered the last read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            from_ram_q <= 1'b0;
        end else if (bus_rd) begin
            from_ram_q <= ram_rd;
        end
    end

    assign bus_rdata = from_ram_q ? ram_rdata : rom_rdata;

    a_r2_index: assert property (@(posedge clk) disable iff (!rst_n)
        in_shadow |-> sh_idx == bus_addr[SH_AW-1:0]);

    a_r4_rom_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !mode_q.rd_en) |=> !from_ram_q);

    a_r5_low_is_rom: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[WIN_AW-1:0] < SH_BASE) |=> !from_ram_q);

    a_r10_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[WIN_AW-1:0] < SH_BASE) |-> !ram_wr);

endmodule

// File: tb/rom_shadow_window_bench.sv
`timescale 1ns/1ps
module rom_shadow_window_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        ctl_valid = 1'b0;
    logic [7:0]  ctl_op = '0;
    logic [7:0]  ctl_arg = '0;
    logic        rom_ld_en = 1'b0;
    logic        rom_ld_bank = 1'b0;
    logic [7:0]  rom_ld_addr = '0;
    logic [7:0]  rom_ld_data = '0;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rom_shadow_window u_rom_shadow_window (
        .clk (clk), .rst_n (rst_n),
        .bus_addr (bus_addr), .bus_rd (bus_rd), .bus_wr (bus_wr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .ctl_valid (ctl_valid), .ctl_op (ctl_op), .ctl_arg (ctl_arg),
        .rom_ld_en (rom_ld_en), .rom_ld_bank (rom_ld_bank),
        .rom_ld_addr (rom_ld_addr), .rom_ld_data (rom_ld_data)
    );

    // Behavioural reference model
    logic [7:0] rom_m [0:1][0:255];
    logic [7:0] ram_m [0:127];
    bit         ram_k [0:127];
    int         mode_m = 0;
    int         bank_m = 0;
    bit         exp_valid = 1'b0;
    bit         exp_known = 1'b0;
    logic [7:0] exp_data = '0;
    string      exp_tag = "";
    string      cur_tag = "";

    initial begin
        for (int i = 0; i < 128; i++) ram_k[i] = 1'b0;
    end

    always @(posedge clk) begin
        int m;
        m = int'(bus_addr) & 16'h3FFF;
        if (!rst_n) begin
            mode_m = 0;
            bank_m = 0;
            exp_valid = 1'b0;
        end else begin
            if (bus_rd) begin
                if (m >= 16'h3F80 && (mode_m & 2) != 0) begin
                    exp_data  = ram_m[m & 127];
                    exp_known = ram_k[m & 127];
                end else begin
                    exp_data  = rom_m[bank_m][m & 255];
                    exp_known = 1'b1;
                end
                exp_valid = 1'b1;
                exp_tag   = cur_tag;
            end
            if (bus_wr && m >= 16'h3F80 && (mode_m & 1) != 0) begin
                ram_m[m & 127] = bus_wdata;
                ram_k[m & 127] = 1'b1;
            end
            if (ctl_valid) begin
                if (ctl_op == 8'h24) mode_m = int'(ctl_arg) & 3;
                else if (ctl_op == 8'h26) bank_m = 0;
                else if (ctl_op == 8'h27) bank_m = 1;
            end
        end
        if (rom_ld_en) rom_m[rom_ld_bank][rom_ld_addr] = rom_ld_data;
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done && rst_n && exp_valid && exp_known) begin
            checks++;
            if (bus_rdata !== exp_data) begin
                fails++;
                $display("FAIL %s: rdata=%h expected=%h", exp_tag, bus_rdata, exp_data);
            end
        end
    end

    task automatic step(input logic rd, input logic wr, input logic [19:0] a,
                        input logic [7:0] d, input logic cv, input logic [7:0] op,
                        input logic [7:0] arg, input string tag);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
        ctl_valid = cv; ctl_op = op; ctl_arg = arg; cur_tag = tag;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; ctl_valid = 1'b0;
    endtask

    task automatic rd(input logic [19:0] a, input string tag);
        step(1'b1, 1'b0, a, 8'h00, 1'b0, 8'h00, 8'h00, tag);
    endtask

    task automatic wr(input logic [19:0] a, input logic [7:0] d);
        step(1'b0, 1'b1, a, d, 1'b0, 8'h00, 8'h00, "");
    endtask

    task automatic cmd(input logic [7:0] op, input logic [7:0] arg);
        step(1'b0, 1'b0, 20'h0, 8'h00, 1'b1, op, arg, "");
    endtask

    task automatic load(input logic b, input logic [7:0] i, input logic [7:0] d);
        rom_ld_en = 1'b1; rom_ld_bank = b; rom_ld_addr = i; rom_ld_data = d;
        @(negedge clk);
        rom_ld_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not end, actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R11: fill both banks through the load port
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 256; i++)
                load(b[0], 8'(i), 8'(i * 13 + b * 8'h5B + 7));
        idle(2);
        rst_n = 1'b1;
        idle(1);

        // R8: after reset, mode 0 and bank 0: overlay shows ROM
        rd(20'h03F80, "R8");
        rd(20'h00010, "R8");
        idle(3);                       // R9: byte held while idle

        // R3/R2: enable both, write and read back
        cmd(8'h24, 8'h03);
        wr(20'h03F90, 8'hAA);
        rd(20'h03F90, "R2");
        // R3: read only, write is dropped
        cmd(8'h24, 8'h02);
        wr(20'h03F90, 8'h55);
        rd(20'h03F90, "R3");
        // R4: write only, overlay read still returns ROM
        cmd(8'h24, 8'h01);
        wr(20'h03FA0, 8'h11);
        rd(20'h03FA0, "R4");
        cmd(8'h24, 8'h03);
        rd(20'h03FA0, "R4");

        // R10/R5: writes outside the overlay are dropped
        wr(20'h00100, 8'h77);
        rd(20'h00100, "R10");
        wr(20'h03F7F, 8'h66);
        rd(20'h03F7F, "R5");
        wr(20'h03F80, 8'h5C);
        rd(20'h03F80, "R2");

        // R1: upper address bits are ignored
        wr(20'h07FF0, 8'hC3);
        rd(20'h03FF0, "R1");
        wr(20'hFFFFF, 8'h3E);
        rd(20'h03FFF, "R1");
        rd(20'hC3F85, "R1");
        rd(20'h54020, "R1");

        // R6: bank select and ignored opcode
        cmd(8'h27, 8'h00);
        rd(20'h00020, "R6");
        rd(20'h03F90, "R6");
        cmd(8'h25, 8'h00);
        rd(20'h00021, "R6");
        cmd(8'h26, 8'h00);
        rd(20'h00021, "R6");

        // R7: argument upper bits ignored
        cmd(8'h24, 8'hFC);
        rd(20'h03F90, "R7");
        cmd(8'h24, 8'hFF);
        rd(20'h03F90, "R7");

        // R12: command with read uses old state
        step(1'b1, 1'b0, 20'h03F90, 8'h00, 1'b1, 8'h24, 8'h00, "R12");
        rd(20'h03F90, "R12");
        step(1'b1, 1'b0, 20'h00040, 8'h00, 1'b1, 8'h27, 8'h00, "R12");
        rd(20'h00040, "R12");
        cmd(8'h26, 8'h00);
        // R12: write with mode command uses old write enable (clear)
        step(1'b0, 1'b1, 20'h03F90, 8'h99, 1'b1, 8'h24, 8'h03, "R12");
        rd(20'h03F90, "R12");
        // R12: same-cycle read and write of one byte returns old byte
        step(1'b1, 1'b1, 20'h03F90, 8'h42, 1'b0, 8'h00, 8'h00, "R12");
        rd(20'h03F90, "R12");

        // R11: reload a byte and read it
        load(1'b1, 8'h33, 8'hE1);
        cmd(8'h27, 8'h00);
        rd(20'h00033, "R11");
        cmd(8'h26, 8'h00);

        // R2: walk all shadow bytes
        for (int i = 0; i < 128; i++) wr(20'h03F80 + 20'(i), 8'(i ^ 8'h3C));
        for (int i = 0; i < 128; i++) rd(20'h03F80 + 20'(i), "R2");

        // R5: walk ROM in both banks
        for (int i = 0; i < 256; i += 5) rd(20'(i), "R5");
        cmd(8'h27, 8'h00);
        for (int i = 0; i < 256; i += 7) rd(20'h01000 + 20'(i), "R5");

        // R8: mid-run reset clears mode and bank
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        rd(20'h03F90, "R8");
        rd(20'h00030, "R8");
        idle(2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule